// File: doc/BRIEF.md
# Masked GPIO Output Port with Per-Pin Change Events

This block is the output side of a general-purpose I/O port. Software programs two 24-bit registers one byte at a time: a data register and an output-enable register. The block drives each pin with the data bit ANDed with its enable bit, so a pin whose enable is clear is held low. Every pin whose driven value changes as a result of a register write is reported to the surrounding logic as an event.

Each event is a one-cycle strobe on that pin's bit of a strobe vector, together with a level vector that carries the new driven value. Both registers can be read back byte by byte. The registers are 24 bits wide, but only the low 16 bits have physical pins. The upper byte of each register is storage that can be read and written and drives nothing.

Top module: `gpo_notify_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), both registers read 0, pin_drive is 0 and evt_strobe is 0. The stored previous level is also 0, so the first write after reset compares against all-zero pins.
- R2: A write with acc_addr 0x78, 0x79 or 0x7A replaces data register bits [7:0], [15:8] or [23:16] respectively and leaves the other two bytes unchanged. A read at the same offset returns that byte on acc_rdata in the same cycle.
- R3: A write with acc_addr 0x7C, 0x7D or 0x7E replaces output-enable bits [7:0], [15:8] or [23:16] respectively and leaves the other bytes unchanged. Reads at those offsets return the stored byte.
- R4: From the cycle after a write, pin_drive[i] equals data bit i AND enable bit i for each pin i from 0 to 15.
- R5: In the cycle after a mapped write, evt_strobe[i] is 1 exactly for the pins whose driven value differs from their value before that write. evt_level equals the new pin_drive.
- R6: evt_strobe is all zero in any cycle that does not follow a mapped write. It is also all zero after a write that leaves every driven value unchanged.
- R7: Register bits 16 to 23 reach no pin: writes to 0x7A or 0x7E never change pin_drive and never raise a strobe. Writes to any address other than the six register offsets change nothing, and reads at such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_wr | input | 1 | Byte write strobe |
| acc_addr | input | 8 | Byte offset for a read or write |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte at acc_addr (combinational) |
| pin_drive | output | 16 | Driven pin values (data AND enable) |
| evt_strobe | output | 16 | One-cycle per-pin change strobes |
| evt_level | output | 16 | New pin levels that go with the strobes |

## Verification
The bench builds the block with its default parameters: three byte lanes per register, 16 pins, and base offsets 0x78 and 0x7C. With these values the upper lane exists in both registers but has no pin behind it, so R7's storage-only bits can be written and read back while the bench checks that no pin or strobe moves. The vector table interleaves data and enable writes so that enabling, disabling and rewriting the same value each give a known strobe pattern. A reset taken mid-run shows that the stored previous level is cleared.

// File: rtl/gpo_notify_pkg.sv
// Package: shared constants for the masked GPIO output port.
// Assumes byte-wide software access; every register is a whole number of bytes.
package gpo_notify_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/gpo_byte_reg.sv
// Module: byte-addressable register of LANES bytes at consecutive offsets from BASE.
// Writes replace a single byte lane. Reads return the addressed lane, or 0 when
// acc_addr hits no lane. Exposes the low OUT_W bits of both the current and the
// next-state value, so that a consumer can act in the same cycle as the write.
// Assumes OUT_W <= LANES*8.
module gpo_byte_reg
    import gpo_notify_pkg::*;
#(
    parameter int              LANES  = 3,
    parameter int              ADDR_W = 8,
    parameter int              OUT_W  = 16,
    parameter logic [ADDR_W-1:0] BASE = 8'h78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output logic [OUT_W-1:0]  q_lo,
    output logic [OUT_W-1:0]  next_lo,
    output logic              wr_hit,
    output byte_t             rd_byte
);
    localparam int REG_W = LANES * BYTE_W;

    logic [REG_W-1:0] q;
    logic [REG_W-1:0] q_next;
    logic [LANES-1:0] sel;

    // Per-lane address decode and next-state byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel[l] = (addr == ADDR_W'(int'(BASE) + l));
        assign q_next[l*BYTE_W +: BYTE_W] = (wr_en && sel[l]) ? wdata
                                                              : q[l*BYTE_W +: BYTE_W];
    end

    // Register storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // Read mux: the selected lane, or zero when no lane matches.
    always_comb begin
        rd_byte = '0;
        for (int l = 0; l < LANES; l++) begin
            if (sel[l]) rd_byte = q[l*BYTE_W +: BYTE_W];
        end
    end

    assign wr_hit  = wr_en && (|sel);
    assign q_lo    = q[OUT_W-1:0];
    assign next_lo = q_next[OUT_W-1:0];
endmodule

// File: rtl/gpo_change_detect.sv
// Module: per-pin change detector. On each update it compares the new effective
// level with the stored previous level, strobes the pins that differ for one
// cycle and stores the new level. Strobes stay zero in cycles without an update.
// Assumes eff_next is valid in the same cycle as upd.
module gpo_change_detect #(
    parameter int PIN_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [PIN_N-1:0] eff_next,
    output logic [PIN_N-1:0] evt_strobe,
    output logic [PIN_N-1:0] evt_level
);
    // Compare with the previous level, emit strobes, keep the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_strobe <= '0;
            evt_level  <= '0;
        end else if (upd) begin
            evt_strobe <= evt_level ^ eff_next;
            evt_level  <= eff_next;
        end else begin
            evt_strobe <= '0;
        end
    end
endmodule

// File: rtl/gpo_notify_top.sv
// Module: masked GPIO output port with per-pin change events.
// Holds a data register and an output-enable register (REG_LANES bytes each).
// Drives pins with data AND enable, and raises one-cycle strobes for the pins
// whose driven value changed because of a register write.
// Assumes PIN_N <= REG_LANES*8 and that the two register windows do not overlap.
module gpo_notify_top
    import gpo_notify_pkg::*;
#(
    parameter int                REG_LANES = 3,
    parameter int                PIN_N     = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_BASE = 8'h78,
    parameter logic [ADDR_W-1:0] OE_BASE   = 8'h7C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic [PIN_N-1:0]  pin_drive,
    output logic [PIN_N-1:0]  evt_strobe,
    output logic [PIN_N-1:0]  evt_level
);
    logic [PIN_N-1:0] data_q, data_nx, oe_q, oe_nx;
    logic             data_hit, oe_hit;
    byte_t            data_rd, oe_rd;

    gpo_byte_reg #(
        .LANES(REG_LANES), .ADDR_W(ADDR_W), .OUT_W(PIN_N), .BASE(DATA_BASE)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .addr(acc_addr),
        .wdata(acc_wdata), .q_lo(data_q), .next_lo(data_nx),
        .wr_hit(data_hit), .rd_byte(data_rd)
    );

    gpo_byte_reg #(
        .LANES(REG_LANES), .ADDR_W(ADDR_W), .OUT_W(PIN_N), .BASE(OE_BASE)
    ) u_oe (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .addr(acc_addr),
        .wdata(acc_wdata), .q_lo(oe_q), .next_lo(oe_nx),
        .wr_hit(oe_hit), .rd_byte(oe_rd)
    );

    gpo_change_detect #(.PIN_N(PIN_N)) u_detect (
        .clk(clk), .rst_n(rst_n), .upd(data_hit | oe_hit),
        .eff_next(data_nx & oe_nx),
        .evt_strobe(evt_strobe), .evt_level(evt_level)
    );

    // Pins follow the stored registers; disabled pins are held low.
    assign pin_drive = data_q & oe_q;
    // Windows are disjoint, so OR-ing the two read bytes selects one.
    assign acc_rdata = data_rd | oe_rd;
endmodule

// File: rtl/gpo_notify_chk.sv
// Module: assertion checker for gpo_notify_top, attached with bind.
// Relates the pin outputs to the event outputs across cycles.
module gpo_notify_chk #(
    parameter int PIN_N = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_wr,
    input logic [PIN_N-1:0] pin_drive,
    input logic [PIN_N-1:0] evt_strobe,
    input logic [PIN_N-1:0] evt_level
);
    // R1: one cycle after reset, pins and strobes are clear.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_drive == '0 && evt_strobe == '0));

    // R5: strobes are exactly the pins whose driven value moved.
    a_r5_strobe_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (evt_strobe == (pin_drive ^ $past(pin_drive))));

    // R5: the event level matches the driven pins.
    a_r5_level_match: assert property (@(posedge clk) disable iff (!rst_n)
        evt_level == pin_drive);

    // R6: no write, no strobe in the next cycle.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> (evt_strobe == '0));

    // R6: pins only move after a write.
    a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(pin_drive));
endmodule

bind gpo_notify_top gpo_notify_chk #(.PIN_N(PIN_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr),
    .pin_drive(pin_drive), .evt_strobe(evt_strobe), .evt_level(evt_level)
);

// File: tb/gpo_notify_top_bench.sv
module gpo_notify_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic [7:0]  acc_rdata;
    logic [15:0] pin_drive, evt_strobe, evt_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpo_notify_top u_gpo_notify_top (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pin_drive(pin_drive),
        .evt_strobe(evt_strobe), .evt_level(evt_level)
    );

    // {addr, wdata, expected pin_drive, expected strobe}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {8'h7C, 8'hFF, 16'h0000, 16'h0000},
        {8'h78, 8'hA5, 16'h00A5, 16'h00A5},
        {8'h79, 8'h3C, 16'h00A5, 16'h0000},
        {8'h7D, 8'hF0, 16'h30A5, 16'h3000},
        {8'h78, 8'h5A, 16'h305A, 16'h00FF},
        {8'h7A, 8'hFF, 16'h305A, 16'h0000},
        {8'h7E, 8'hFF, 16'h305A, 16'h0000},
        {8'h40, 8'hFF, 16'h305A, 16'h0000},
        {8'h7C, 8'h0F, 16'h300A, 16'h0050},
        {8'h7D, 8'hFF, 16'h3C0A, 16'h0C00},
        {8'h78, 8'h5A, 16'h3C0A, 16'h0000},
        {8'h79, 8'h00, 16'h000A, 16'h3C00}
    };

    task automatic chk16(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        acc_addr = a;
        #1;
        chk16(req, $sformatf("read@%h", a), {8'h00, acc_rdata}, {8'h00, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk16("R1", "pin_drive", pin_drive, 16'h0000);
        chk16("R1", "strobe", evt_strobe, 16'h0000);
        rd_chk("R1", 8'h78, 8'h00);
        rd_chk("R1", 8'h7C, 8'h00);

        // R4 R5 R6 R7: vector walk
        for (int i = 0; i < NV; i++) begin
            wr_byte(VEC[i][47:40], VEC[i][39:32]);
            chk16("R4", $sformatf("v%0d pin_drive", i), pin_drive, VEC[i][31:16]);
            chk16("R5", $sformatf("v%0d strobe", i), evt_strobe, VEC[i][15:0]);
            chk16("R5", $sformatf("v%0d level", i), evt_level, VEC[i][31:16]);
            @(negedge clk);
            chk16("R6", $sformatf("v%0d idle strobe", i), evt_strobe, 16'h0000);
        end

        // R2 R3 R7: byte readback and unmapped reads
        rd_chk("R2", 8'h78, 8'h5A);
        rd_chk("R2", 8'h79, 8'h00);
        rd_chk("R2", 8'h7A, 8'hFF);
        rd_chk("R3", 8'h7C, 8'h0F);
        rd_chk("R3", 8'h7D, 8'hFF);
        rd_chk("R3", 8'h7E, 8'hFF);
        rd_chk("R7", 8'h7B, 8'h00);
        rd_chk("R7", 8'h40, 8'h00);
        rd_chk("R7", 8'h7F, 8'h00);

        // R1: mid-run reset clears registers and previous level
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk16("R1", "pin after reset", pin_drive, 16'h0000);
        chk16("R1", "strobe after reset", evt_strobe, 16'h0000);
        rd_chk("R1", 8'h7A, 8'h00);
        rd_chk("R1", 8'h7D, 8'h00);
        wr_byte(8'h7C, 8'h01);
        chk16("R1", "strobe enable only", evt_strobe, 16'h0000);
        wr_byte(8'h78, 8'h01);
        chk16("R1", "strobe from cleared prev", evt_strobe, 16'h0001);
        chk16("R4", "pin bit0", pin_drive, 16'h0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule